// File: doc/BRIEF.md
# Multi-Channel Sample Block Capture Buffer

This block gathers 16-bit converter samples from several channels into a dual-port memory. Each input sample arrives with a one-cycle valid strobe and a channel number. The capture side keeps one write index for each channel. It stores the sample at that channel's next slot inside the memory half that is currently filling. Once every channel has delivered a full block of samples, the block raises a level interrupt and reports which half now holds finished data. Capture then switches to the other half and goes on. The processor reads any stored sample at random through a private synchronous read port. While it does so, new samples keep landing in the other half.

The interrupt stays high until the processor pulses an acknowledge. If another block completes while an earlier one is still unacknowledged, a sticky overrun flag is set. Everything runs on one clock. The idle gaps between strobes are left to the sample source.

Top module: `capture_buffer`

## Requirements
- R1: After reset the outputs are irq=0, overrun=0 and readyHalf=0, and the first sample of each channel goes to half 0 at slot index 0.
- R2: Sample number k (counting from 0) of channel c within a block is written to address h*CHANNELS*BLOCK_LEN + c*BLOCK_LEN + k, where h is the half that is filling.
- R3: rdData shows the memory word at rdAddr one clock edge after the address is presented.
- R4: irq rises on the clock edge that stores the last of the BLOCK_LEN samples of the final channel to finish the block. It does not rise before that edge.
- R5: When a block completes, readyHalf takes the number of the half just filled, and capture continues in the other half. The halves alternate 0, 1, 0, and so on.
- R6: Without an acknowledge, irq stays high. A one-cycle irqAck pulse clears irq on the next edge.
- R7: If a block completes while irq is high and irqAck is low in that cycle, overrun is set. Only reset clears it.
- R8: If irqAck arrives in the same cycle as a block completion, irq stays high and overrun keeps its value.
- R9: A channel that already holds BLOCK_LEN samples in the current block ignores further samples until the block completes. They are neither stored nor counted.
- R10: A strobe whose channel number is CHANNELS or greater is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleValid | input | 1 | One-cycle strobe marking a new sample |
| sampleChan | input | CHAN_W | Channel number of the sample |
| sampleData | input | DATA_W | Sample value |
| rdAddr | input | ADDR_W | Processor read address |
| rdData | output | DATA_W | Read data, one clock after rdAddr |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Block-ready level interrupt |
| overrun | output | 1 | Sticky flag: a block completed while irq was pending |
| readyHalf | output | 1 | Half that holds the most recently completed block |

## Verification
The acknowledge pulse and a block completion can land on the same clock edge. One clears the interrupt and the other sets it, and the overrun decision depends on both at once. The bench provokes this by driving irqAck together with the sample that finishes a block. It expects irq still high and overrun unchanged. In a later block it completes without an acknowledge and expects overrun to set and stay set. Every block is followed by a full read-back of both halves against a model that is built from the address formula.

// File: rtl/capture_pkg.sv
package capture_pkg;
  typedef struct packed {
    logic wrEn;
    logic wrHalf;
    logic blockDone;
  } capStrobes_t;
endpackage

// File: rtl/capture_ram.sv
module capture_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH = 1600,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    rdData <= store[rdAddr];
  end
endmodule

// File: rtl/capture_datapath.sv
module capture_datapath
  import capture_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHANNELS = 4,
  parameter int BLOCK_LEN = 200,
  parameter int CHAN_W = 2,
  parameter int IDX_W = 8,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobes_t       strobes,
  input  logic [CHAN_W-1:0] wrChan,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int HALF_SZ = CHANNELS * BLOCK_LEN;
  localparam int DEPTH = 2 * HALF_SZ;

  logic [ADDR_W-1:0] wrAddr;

  assign wrAddr = (strobes.wrHalf ? ADDR_W'(HALF_SZ) : '0)
                + ADDR_W'(wrChan) * ADDR_W'(BLOCK_LEN)
                + ADDR_W'(wrIdx);

  capture_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) ram (
    .clk   (clk),
    .wrEn  (strobes.wrEn),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

  // R2
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |-> (int'(wrAddr) < DEPTH));
endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl
  import capture_pkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int BLOCK_LEN = 200,
  parameter int CHAN_W = 2,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [CHAN_W-1:0] sampleChan,
  input  logic              irqAck,
  output capStrobes_t       strobes,
  output logic [IDX_W-1:0]  wrIdx,
  output logic              irq,
  output logic              overrun,
  output logic              readyHalf
);
  logic [CHANNELS-1:0] hitVec, lastVec, doneVec;
  logic [CHANNELS-1:0][IDX_W-1:0] idxVec;
  logic fillHalf;
  logic blockDone;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [IDX_W-1:0] idxR;
    logic doneR;

    assign hitVec[c]  = sampleValid && (sampleChan == CHAN_W'(c)) && !doneR;
    assign lastVec[c] = hitVec[c] && (idxR == IDX_W'(BLOCK_LEN - 1));
    assign idxVec[c]  = idxR;
    assign doneVec[c] = doneR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        idxR  <= '0;
        doneR <= 1'b0;
      end else if (blockDone) begin
        idxR  <= '0;
        doneR <= 1'b0;
      end else if (hitVec[c]) begin
        if (lastVec[c]) begin
          idxR  <= '0;
          doneR <= 1'b1;
        end else begin
          idxR <= idxR + 1'b1;
        end
      end
    end

    // R9
    idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
      int'(idxR) < BLOCK_LEN);
  end

  assign blockDone = &(doneVec | lastVec);

  always_comb begin
    wrIdx = '0;
    for (int c = 0; c < CHANNELS; c++) begin
      if (hitVec[c]) wrIdx = idxVec[c];
    end
  end

  assign strobes.wrEn      = |hitVec;
  assign strobes.wrHalf    = fillHalf;
  assign strobes.blockDone = blockDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillHalf  <= 1'b0;
      readyHalf <= 1'b0;
      irq       <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (blockDone) begin
        readyHalf <= fillHalf;
        fillHalf  <= ~fillHalf;
        irq       <= 1'b1;
        if (irq && !irqAck) overrun <= 1'b1;
      end else if (irqAck) begin
        irq <= 1'b0;
      end
    end
  end

  // R4
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(blockDone));
  // R6
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqAck) |=> irq);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !blockDone) |=> !irq);
  // R7
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  // R5
  half_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |=> (readyHalf != fillHalf));
  // R8
  ack_collide_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockDone && irqAck) |=> (irq && $stable(overrun)));
endmodule

// File: rtl/capture_buffer.sv
module capture_buffer
  import capture_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHANNELS = 4,
  parameter int BLOCK_LEN = 200,
  parameter int CHAN_W = $clog2(CHANNELS),
  parameter int ADDR_W = $clog2(2 * CHANNELS * BLOCK_LEN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [CHAN_W-1:0] sampleChan,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              irqAck,
  output logic              irq,
  output logic              overrun,
  output logic              readyHalf
);
  localparam int IDX_W = $clog2(BLOCK_LEN);

  capStrobes_t strobes;
  logic [IDX_W-1:0] wrIdx;

  capture_ctrl #(
    .CHANNELS(CHANNELS), .BLOCK_LEN(BLOCK_LEN), .CHAN_W(CHAN_W), .IDX_W(IDX_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .irqAck(irqAck), .strobes(strobes), .wrIdx(wrIdx), .irq(irq),
    .overrun(overrun), .readyHalf(readyHalf)
  );

  capture_datapath #(
    .DATA_W(DATA_W), .CHANNELS(CHANNELS), .BLOCK_LEN(BLOCK_LEN),
    .CHAN_W(CHAN_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrChan(sampleChan),
    .wrIdx(wrIdx), .wrData(sampleData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/capture_buffer_test.sv
module capture_buffer_test;
  localparam int CH = 3;
  localparam int BL = 4;
  localparam int CW = 2;
  localparam int AW = $clog2(2 * CH * BL);
  localparam int DEPTH = 2 * CH * BL;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [CW-1:0] sampleChan = '0;
  logic [15:0] sampleData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [15:0] rdData;
  logic irqAck = 1'b0;
  logic irq, overrun, readyHalf;

  capture_buffer #(.DATA_W(16), .CHANNELS(CH), .BLOCK_LEN(BL), .CHAN_W(CW)) uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleData(sampleData), .rdAddr(rdAddr), .rdData(rdData), .irqAck(irqAck),
    .irq(irq), .overrun(overrun), .readyHalf(readyHalf)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] expMem [DEPTH];
  bit written [DEPTH];
  int mCnt [CH];
  bit mDone [CH];
  bit mFill = 0, mReady = 0, mIrq = 0, mOvr = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic modelEdge(bit valid, int c, logic [15:0] d, bit ack);
    bit complete = 0;
    bit all = 1;
    if (valid && c < CH && !mDone[c]) begin
      int a = (mFill ? CH * BL : 0) + c * BL + mCnt[c];
      expMem[a] = d;
      written[a] = 1;
      if (mCnt[c] == BL - 1) mDone[c] = 1;
      else mCnt[c]++;
    end
    for (int i = 0; i < CH; i++) if (!mDone[i]) all = 0;
    complete = all;
    if (complete) begin
      if (mIrq && !ack) mOvr = 1;
      mIrq = 1;
      mReady = mFill;
      mFill = ~mFill;
      for (int i = 0; i < CH; i++) begin mCnt[i] = 0; mDone[i] = 0; end
    end else if (ack) begin
      mIrq = 0;
    end
  endtask

  task automatic checkOuts(string tag);
    chk({tag, " irq"}, int'(irq), int'(mIrq));
    chk({tag, " overrun"}, int'(overrun), int'(mOvr));
    chk({tag, " readyHalf"}, int'(readyHalf), int'(mReady));
  endtask

  task automatic cycle(bit valid, int c, logic [15:0] d, bit ack, string tag);
    @(negedge clk);
    sampleValid = valid;
    sampleChan = CW'(c);
    sampleData = d;
    irqAck = ack;
    @(posedge clk);
    modelEdge(valid, c, d, ack);
    @(negedge clk);
    sampleValid = 1'b0;
    irqAck = 1'b0;
    checkOuts(tag);
  endtask

  task automatic dump(string tag);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      rdAddr = AW'(a);
      @(posedge clk);
      @(negedge clk);
      if (written[a]) chk(tag, int'(rdData), int'(expMem[a]));
    end
  endtask

  function automatic logic [15:0] val(int blk, int c, int k);
    return 16'(16'hA000 + blk * 256 + c * 16 + k);
  endfunction

  task automatic fullBlock(int blk, bit ackLast, string tag);
    for (int k = 0; k < BL; k++)
      for (int c = 0; c < CH; c++)
        cycle(1, c, val(blk, c, k), (ackLast && k == BL - 1 && c == CH - 1), tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) written[i] = 0;
    for (int i = 0; i < CH; i++) begin mCnt[i] = 0; mDone[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    checkOuts("R1 reset");

    // Block 0 round-robin; irq must stay low until the final sample (R4)
    fullBlock(0, 0, "R4 block0");
    dump("R1 R2 block0 readback");

    // R6: irq held without ack, then cleared by a pulse
    cycle(0, 0, 0, 0, "R6 hold");
    cycle(0, 0, 0, 0, "R6 hold");
    cycle(0, 0, 0, 1, "R6 ack");

    // Block 1: channel 0 fills first, extra ch0 samples dropped (R9)
    for (int k = 0; k < BL; k++) cycle(1, 0, val(1, 0, k), 0, "R5 block1");
    cycle(1, 0, 16'hDEAD, 0, "R9 drop");
    cycle(1, 0, 16'hBEEF, 0, "R9 drop");
    for (int c = 1; c < CH; c++)
      for (int k = 0; k < BL; k++) cycle(1, c, val(1, c, k), 0, "R5 block1");
    dump("R9 block1 readback");

    // Block 2: invalid channel ignored (R10); ack collides with completion (R8)
    for (int c = 0; c < CH; c++)
      for (int k = 0; k < BL; k++) begin
        if (k == 2) cycle(1, 3, 16'h5555, 0, "R10 invalid chan");
        cycle(1, c, val(2, c, k), (c == CH - 1 && k == BL - 1), "R8 collide");
      end
    dump("R10 block2 readback");

    // Block 3: completes with irq pending and no ack (R7)
    fullBlock(3, 0, "R7 overrun");
    dump("R3 block3 readback");
    cycle(0, 0, 0, 1, "R7 sticky after ack");
    cycle(0, 0, 0, 0, "R7 sticky");

    // Block 4: halves keep alternating (R5)
    fullBlock(4, 0, "R5 block4");
    dump("R2 block4 readback");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule